// File: doc/BRIEF.md
# Receive Message Identifier Filter

This block sits between a serial bus symbol decoder and the receive register set of a bus controller. It decides, frame by frame, whether a received message is handed to software. The first byte that follows a start-of-frame event is the message identifier. That byte indexes a 256-bit acceptance bitmap, which is held in 32 byte-wide registers on a simple register port. An identifier whose bitmap bit is set opens the frame: the identifier and the bytes that follow go to the receive data register, and the usual flags and interrupts work. An identifier whose bit is clear closes the frame until a minimum end-of-frame event. While the frame is closed, no data moves and the data flags stay quiet. Break reporting and the idle flag stay live.

The same gate applies when the node is transmitting. If the node's own identifier is rejected, the data flags are suppressed. The CRC, invalid-frame and invalid-bit errors are still reported, so software can judge how its transmission went. Software can also put the receiver to sleep for the rest of an accepted frame. All bus timing, CRC checking and arbitration happen upstream and reach this block only as one-cycle event strobes.

Top module: `rxIdGate`

## Requirements
- R1: Filter register k (register address k, 0 to 31) bit b is the acceptance bit for identifier 8*k+b. All filter registers reset to 0 and read back what was written.
- R2: When a frame is open for its identifier, the first byte strobe after a start-of-frame whose acceptance bit is 1 has two effects one cycle later: the byte appears in the receive data register (address 32), and the full flag (status bit 0) is set.
- R3: When the acceptance bit of the identifier is 0, the identifier and every later byte of the frame leave the receive data register and the full, overrun (bit 1) and end-of-data (bit 2) flags unchanged. End-of-data events are ignored as well.
- R4: A minimum end-of-frame event ends a rejected frame, and the next start-of-frame evaluates its identifier afresh.
- R5: During a rejected received frame, a break event still sets the break flag (bit 4) and an idle event still sets the idle flag (bit 3). CRC (bit 5), invalid-frame (bit 6) and invalid-bit (bit 7) error events are not recorded.
- R6: When txActive is high at start-of-frame and the identifier is rejected, CRC, invalid-frame and invalid-bit errors are still recorded, while the full, overrun and end-of-data flags stay clear.
- R7: While the block is waiting for the identifier byte, a write-one-to-clear of the invalid-frame or invalid-bit flag is ignored. Once the identifier has been compared, the same write clears the flag.
- R8: A byte accepted while the full flag is set sets the overrun flag and leaves the older byte in the receive data register.
- R9: Control register bit 0 (address 34) is the sleep request. Once set, it stops the remaining bytes and the end-of-data event of an accepted frame from loading data or setting flags. It clears itself on minimum end-of-frame or break.
- R10: The status register (address 33) has bit 0 full, 1 overrun, 2 end-of-data, 3 idle, 4 break, 5 CRC, 6 invalid-frame, 7 invalid-bit. Writing a 1 to a bit clears it.
- R11: irqRx equals control bit 1 AND (full OR end-of-data). irqErr equals control bit 2 AND (overrun OR break OR CRC OR invalid-frame OR invalid-bit).
- R12: An end-of-data event in an accepted, awake frame sets the end-of-data flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 6 | Register port address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| sofEv | input | 1 | Start-of-frame event |
| byteEv | input | 1 | Received byte strobe |
| byteData | input | 8 | Received byte value |
| eodEv | input | 1 | End-of-data event |
| eofMinEv | input | 1 | Minimum end-of-frame event |
| breakEv | input | 1 | Break symbol event |
| idleEv | input | 1 | Bus idle event |
| crcErrEv | input | 1 | CRC error event |
| ifdErrEv | input | 1 | Invalid-frame error event |
| ibdErrEv | input | 1 | Invalid-bit error event |
| txActive | input | 1 | Node is transmitting the current frame |
| rxData | output | 8 | Receive data register |
| statusFlags | output | 8 | Status register contents |
| irqRx | output | 1 | Receive interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
The identifier gate is exercised with several identifiers. One identifier has its bit set in a filter register. Another is its immediate neighbour, whose bit is clear, so the tests show that the bit index is decoded exactly. A received frame and an own-transmitted frame carry the same rejected identifier, which separates the two error-masking rules. Trailing bytes, end-of-data, break, idle and error events are injected inside rejected, accepted and sleeping frames. Clears are attempted before and after the identifier comparison, to show which events each frame state lets through.

// File: rtl/rxIdGatePkg.sv
package rxIdGatePkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_ID,
    ST_ACCEPT,
    ST_REJECT
  } frameState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic setOvr;
    logic setEod;
    logic allowErr;
    logic holdPre;
    logic clrSleep;
  } gateStb_t;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_EOD  = 2;
  localparam int ST_IDL  = 3;
  localparam int ST_BRK  = 4;
  localparam int ST_CRC  = 5;
  localparam int ST_IFD  = 6;
  localparam int ST_IBD  = 7;

  localparam int CT_SLEEP = 0;
  localparam int CT_RXIE  = 1;
  localparam int CT_ERRIE = 2;

endpackage

// File: rtl/rxIdGateCtrl.sv
module rxIdGateCtrl
  import rxIdGatePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sofEv,
  input  logic     byteEv,
  input  logic     eodEv,
  input  logic     eofMinEv,
  input  logic     breakEv,
  input  logic     txActive,
  input  logic     idHit,
  input  logic     sleepOn,
  input  logic     rxFull,
  output gateStb_t stb
);

  frameState_t state, stateNext;
  logic ownTx;
  logic accepting;
  logic dataByte;

  assign accepting = (state == ST_ACCEPT) && !sleepOn;
  assign dataByte  = byteEv && (((state == ST_WAIT_ID) && idHit) || accepting);

  always_comb begin
    stb          = '0;
    stb.loadData = dataByte && !rxFull;
    stb.setOvr   = dataByte && rxFull;
    stb.setEod   = eodEv && accepting;
    stb.allowErr = (state != ST_REJECT) || ownTx;
    stb.holdPre  = (state == ST_WAIT_ID);
    stb.clrSleep = eofMinEv || breakEv;
  end

  always_comb begin
    stateNext = state;
    if (sofEv) begin
      stateNext = ST_WAIT_ID;
    end else if (eofMinEv || breakEv) begin
      stateNext = ST_IDLE;
    end else if (byteEv && (state == ST_WAIT_ID)) begin
      stateNext = idHit ? ST_ACCEPT : ST_REJECT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ownTx <= 1'b0;
    end else begin
      state <= stateNext;
      if (sofEv) ownTx <= txActive;
    end
  end

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REJECT) |-> (!stb.loadData && !stb.setOvr && !stb.setEod)); // R3

  AST_EOF_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (eofMinEv && !sofEv) |=> (state == ST_IDLE)); // R4

  AST_RX_ERR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_REJECT) && !ownTx) |-> !stb.allowErr); // R5

endmodule

// File: rtl/rxIdGateData.sv
module rxIdGateData
  import rxIdGatePkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [ID_W-1:0]   byteData,
  input  logic              idleEv,
  input  logic              breakEv,
  input  logic              crcErrEv,
  input  logic              ifdErrEv,
  input  logic              ibdErrEv,
  input  gateStb_t          stb,
  output logic              idHit,
  output logic              sleepOn,
  output logic              rxFull,
  output logic [7:0]        rxData,
  output logic [7:0]        statusFlags,
  output logic              irqRx,
  output logic              irqErr
);

  localparam int NUM_BITS  = 1 << ID_W;
  localparam int NUM_REGS  = NUM_BITS / 8;
  localparam int RXD_ADDR  = NUM_REGS;
  localparam int STAT_ADDR = NUM_REGS + 1;
  localparam int CTRL_ADDR = NUM_REGS + 2;

  logic [7:0]          filtReg [NUM_REGS];
  logic [NUM_BITS-1:0] filtFlat;
  logic [7:0]          statReg;
  logic [7:0]          rxDataReg;
  logic [2:0]          ctrlReg;
  logic [7:0]          setVec;
  logic [7:0]          clrVec;
  logic                statWr;
  logic                ctrlWr;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gFilt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          filtReg[g] <= 8'h00;
        end else if (regWrEn && (regAddr == ADDR_W'(g))) begin
          filtReg[g] <= regWrData;
        end
      end
      assign filtFlat[g*8 +: 8] = filtReg[g];
    end
  endgenerate

  assign idHit = filtFlat[byteData];

  assign statWr = regWrEn && (regAddr == ADDR_W'(STAT_ADDR));
  assign ctrlWr = regWrEn && (regAddr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    setVec          = '0;
    setVec[ST_FULL] = stb.loadData;
    setVec[ST_OVR]  = stb.setOvr;
    setVec[ST_EOD]  = stb.setEod;
    setVec[ST_IDL]  = idleEv;
    setVec[ST_BRK]  = breakEv;
    setVec[ST_CRC]  = crcErrEv && stb.allowErr;
    setVec[ST_IFD]  = ifdErrEv && stb.allowErr;
    setVec[ST_IBD]  = ibdErrEv && stb.allowErr;
    clrVec          = statWr ? regWrData : 8'h00;
    if (stb.holdPre) begin
      clrVec[ST_IFD] = 1'b0;
      clrVec[ST_IBD] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statReg   <= 8'h00;
      rxDataReg <= 8'h00;
      ctrlReg   <= 3'b000;
    end else begin
      statReg <= (statReg & ~clrVec) | setVec;
      if (stb.loadData) rxDataReg <= 8'(byteData);
      if (ctrlWr) ctrlReg <= regWrData[2:0];
      if (stb.clrSleep) ctrlReg[CT_SLEEP] <= 1'b0;
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (regAddr < ADDR_W'(NUM_REGS)) begin
      regRdData = filtReg[regAddr[$clog2(NUM_REGS)-1:0]];
    end else if (regAddr == ADDR_W'(RXD_ADDR)) begin
      regRdData = rxDataReg;
    end else if (regAddr == ADDR_W'(STAT_ADDR)) begin
      regRdData = statReg;
    end else if (regAddr == ADDR_W'(CTRL_ADDR)) begin
      regRdData = {5'b0, ctrlReg};
    end
  end

  assign sleepOn     = ctrlReg[CT_SLEEP];
  assign rxFull      = statReg[ST_FULL];
  assign rxData      = rxDataReg;
  assign statusFlags = statReg;
  assign irqRx  = ctrlReg[CT_RXIE] && (statReg[ST_FULL] || statReg[ST_EOD]);
  assign irqErr = ctrlReg[CT_ERRIE] && (statReg[ST_OVR] || statReg[ST_BRK] ||
                  statReg[ST_CRC] || statReg[ST_IFD] || statReg[ST_IBD]);

  AST_FULL_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[ST_FULL]) |-> $past(stb.loadData)); // R2

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    stb.setOvr |=> $stable(rxDataReg)); // R8

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.holdPre && statReg[ST_IFD]) |=> statReg[ST_IFD]); // R7

  AST_SLEEP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrSleep |=> !ctrlReg[CT_SLEEP]); // R9

  AST_EOD_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statReg[ST_EOD]) |-> $past(stb.setEod)); // R12

endmodule

// File: rtl/rxIdGate.sv
module rxIdGate
  import rxIdGatePkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = $clog2((1 << ID_W) / 8 + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              sofEv,
  input  logic              byteEv,
  input  logic [ID_W-1:0]   byteData,
  input  logic              eodEv,
  input  logic              eofMinEv,
  input  logic              breakEv,
  input  logic              idleEv,
  input  logic              crcErrEv,
  input  logic              ifdErrEv,
  input  logic              ibdErrEv,
  input  logic              txActive,
  output logic [7:0]        rxData,
  output logic [7:0]        statusFlags,
  output logic              irqRx,
  output logic              irqErr
);

  gateStb_t stb;
  logic idHit;
  logic sleepOn;
  logic rxFull;

  rxIdGateCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sofEv    (sofEv),
    .byteEv   (byteEv),
    .eodEv    (eodEv),
    .eofMinEv (eofMinEv),
    .breakEv  (breakEv),
    .txActive (txActive),
    .idHit    (idHit),
    .sleepOn  (sleepOn),
    .rxFull   (rxFull),
    .stb      (stb)
  );

  rxIdGateData #(.ID_W(ID_W), .ADDR_W(ADDR_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .regAddr     (regAddr),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .byteData    (byteData),
    .idleEv      (idleEv),
    .breakEv     (breakEv),
    .crcErrEv    (crcErrEv),
    .ifdErrEv    (ifdErrEv),
    .ibdErrEv    (ibdErrEv),
    .stb         (stb),
    .idHit       (idHit),
    .sleepOn     (sleepOn),
    .rxFull      (rxFull),
    .rxData      (rxData),
    .statusFlags (statusFlags),
    .irqRx       (irqRx),
    .irqErr      (irqErr)
  );

endmodule

// File: tb/sim_rxIdGate.sv
`timescale 1ns/1ps
module sim_rxIdGate;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sofEv = 0, byteEv = 0, eodEv = 0, eofMinEv = 0, breakEv = 0;
  logic       idleEv = 0, crcErrEv = 0, ifdErrEv = 0, ibdErrEv = 0, txActive = 0;
  logic [7:0] byteData = '0;
  logic [7:0] rxData;
  logic [7:0] statusFlags;
  logic       irqRx, irqErr;

  int total = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [5:0] A_RXD  = 6'd32;
  localparam logic [5:0] A_STAT = 6'd33;
  localparam logic [5:0] A_CTRL = 6'd34;

  always #2.5 clk = ~clk;

  rxIdGate u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sofEv(sofEv),
    .byteEv(byteEv), .byteData(byteData), .eodEv(eodEv), .eofMinEv(eofMinEv),
    .breakEv(breakEv), .idleEv(idleEv), .crcErrEv(crcErrEv),
    .ifdErrEv(ifdErrEv), .ibdErrEv(ibdErrEv), .txActive(txActive),
    .rxData(rxData), .statusFlags(statusFlags), .irqRx(irqRx), .irqErr(irqErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // kinds: 0 sof,1 byte,2 eod,3 eofMin,4 break,5 idle,6 crc,7 ifd,8 ibd
  task automatic pulse(input int kind, input logic [7:0] d = 8'h00);
    @(negedge clk);
    byteData = d;
    case (kind)
      0: sofEv = 1; 1: byteEv = 1; 2: eodEv = 1; 3: eofMinEv = 1;
      4: breakEv = 1; 5: idleEv = 1; 6: crcErrEv = 1; 7: ifdErrEv = 1;
      default: ibdErrEv = 1;
    endcase
    @(negedge clk);
    {sofEv, byteEv, eodEv, eofMinEv, breakEv, idleEv, crcErrEv, ifdErrEv, ibdErrEv} = '0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    rdReg(6'd5, v);   chk("R1 filter reset", v, 8'h00);
    rdReg(A_STAT, v); chk("R10 status reset", v, 8'h00);
    chk("R11 irq reset", {irqRx, irqErr}, 0);
  endtask

  task automatic testMap();
    logic [7:0] v;
    wrReg(6'd4, 8'h08);   // identifier 35 accepted, 36 rejected
    rdReg(6'd4, v); chk("R1 filter readback", v, 8'h08);
    wrReg(A_CTRL, 8'h06);
  endtask

  task automatic testAccept();
    logic [7:0] v;
    pulse(0); pulse(1, 8'd35);
    chk("R2 id loaded", rxData, 35);
    chk("R2 full set", statusFlags[0], 1);
    chk("R11 irqRx", irqRx, 1);
    pulse(1, 8'h11);
    chk("R8 overrun set", statusFlags[1], 1);
    chk("R8 data kept", rxData, 35);
    chk("R11 irqErr on overrun", irqErr, 1);
    pulse(2);
    chk("R12 eod set", statusFlags[2], 1);
    pulse(3);
    rdReg(A_RXD, v); chk("R10 rxData address", v, 35);
    wrReg(A_STAT, 8'h02);
    chk("R10 w1c single", statusFlags, 8'h05);
    wrReg(A_STAT, 8'hFF);
    chk("R10 w1c all", statusFlags, 8'h00);
  endtask

  task automatic testReject();
    pulse(0); pulse(1, 8'd36);
    chk("R3 id not loaded", rxData, 35);
    chk("R3 no flags", statusFlags, 8'h00);
    pulse(1, 8'd35); pulse(2);
    chk("R3 later bytes ignored", statusFlags, 8'h00);
    pulse(7); pulse(6); pulse(8);
    chk("R5 errors masked", statusFlags, 8'h00);
    pulse(5);
    chk("R5 idle live", statusFlags, 8'h08);
    pulse(4);
    chk("R5 break live", statusFlags, 8'h18);
    wrReg(A_STAT, 8'hFF);
    pulse(0); pulse(1, 8'd36); pulse(3);
    pulse(0); pulse(1, 8'd35);
    chk("R4 rearmed accept", statusFlags, 8'h01);
    pulse(3);
    wrReg(A_STAT, 8'hFF);
  endtask

  task automatic testOwnTx();
    @(negedge clk) txActive = 1;
    pulse(0);
    @(negedge clk) txActive = 0;
    pulse(1, 8'd36); pulse(6); pulse(7); pulse(8); pulse(1, 8'd35); pulse(2);
    chk("R6 own tx flags", statusFlags, 8'hE0);
    pulse(3);
    wrReg(A_STAT, 8'hFF);
  endtask

  task automatic testPreHold();
    pulse(0); pulse(7);
    chk("R7 ifd pre set", statusFlags[6], 1);
    wrReg(A_STAT, 8'h40);
    chk("R7 ifd clear blocked", statusFlags[6], 1);
    pulse(1, 8'd35);
    wrReg(A_STAT, 8'h40);
    chk("R7 ifd clear after compare", statusFlags[6], 0);
    pulse(3);
    wrReg(A_STAT, 8'hFF);
  endtask

  task automatic testSleep();
    logic [7:0] v;
    pulse(0); pulse(1, 8'd35);
    wrReg(A_STAT, 8'h01);
    wrReg(A_CTRL, 8'h07);
    pulse(1, 8'h22); pulse(2);
    chk("R9 sleep no flags", statusFlags, 8'h00);
    chk("R9 sleep data kept", rxData, 35);
    pulse(3);
    rdReg(A_CTRL, v); chk("R9 sleep self clear", v, 8'h06);
    pulse(0); pulse(1, 8'd35); pulse(1, 8'h44);
    chk("R9 awake next frame", statusFlags, 8'h03);
    pulse(4);
    chk("R11 irqErr break", irqErr, 1);
    wrReg(A_CTRL, 8'h00);
    chk("R11 irq masked", {irqRx, irqErr}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMap();
    testAccept();
    testReject();
    testOwnTx();
    testPreHold();
    testSleep();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule